// File: doc/BRIEF.md
# Multi-Mode Timer Counter Timebase

This block is the counting core of a general-purpose timer. It picks one of two incoming event pulse streams, divides the event rate by 1, 2, 4 or 8, and uses the resulting ticks to advance a counter. The counter can be cut down to 8, 10, 12 or 16 bits. It runs in one of four modes: halted, counting up to a programmed period, free-running, or counting up and then down against the period. A sticky overflow flag records each wrap of the count to zero.

Software reaches the block through three write ports: a control word, the counter value and the period value. The period value is the effective value of compare register 0. The control word and the counter are read back directly. In up mode, if the period is written below the current count, the block schedules a forced return to zero on the next tick. Otherwise the count would have to run all the way around the counter.

Top module: `tmb_timebase`

## Requirements
- R1: After reset the control word, counter, period, direction state, pending-roll state and prescaler residue are all zero.
- R2: Control bits [9:8] select the event source. Code 1 counts `aux_evt` pulses and code 2 counts `main_evt` pulses. Codes 0 and 3 produce no ticks, so the counter holds.
- R3: Control bits [7:6] set the divide ratio to 2^code. A tick occurs once the accumulated events reach the ratio. Events left over stay in the residue and count toward the next tick.
- R4: Mode code 0 in control bits [5:4] stops the counter. Ticks do not change it.
- R5: In mode code 1 (up), a tick sets the counter to 0 and sets the overflow flag when the count equals the period or a roll is pending. Otherwise the tick increments the counter.
- R6: In mode code 2 (continuous), a tick increments the counter. The overflow flag sets when the masked result is 0. Whenever the flag newly sets, the counter reads 0.
- R7: In mode code 3 (up/down), the direction turns down (`cnt_down`=1) when a tick sees a count greater than or equal to the period, and turns up when the tick sees a count of 0. The counter then steps in that direction. The overflow flag sets when a decrement reaches 0.
- R8: Control bits [12:11] select the counter length: code 0 is 16 bits, 1 is 12, 2 is 10 and 3 is 8. The mask applies to every increment, every decrement and every counter write. A write uses the length in force before that cycle.
- R9: A control write stores every bit except bits 2 and 3, which read back as 0. If bit 2 of the written word is 1, the counter is zeroed.
- R10: In up mode, a period write with a value below the current count sets the pending-roll state. The next tick then returns the counter to 0.
- R11: The overflow flag is control bit 0 (`ovf_flag`) and the enable is control bit 1 (`ovf_en`). Once set, the flag stays set until a control write clears it.
- R12: A control or counter write in the same cycle as a tick takes precedence, and that tick's counter step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_evt | input | 1 | Auxiliary event pulse, one event per cycle high |
| main_evt | input | 1 | Main event pulse, one event per cycle high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write data |
| ctl_rdata | output | 16 | Stored control word |
| cnt_rdata | output | 16 | Counter value |
| per_rdata | output | 16 | Period value |
| cnt_down | output | 1 | Up/down direction state, 1 while counting down |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_en | output | 1 | Overflow enable bit |

## Verification
Every result lands on the first rising edge after its stimulus cycle: a write, an event pulse at ratio 1, or the final event that completes a divided tick. There is no extra pipeline stage, because the prescaler forms its tick combinationally from the residue and the current event. The bench drives inputs and samples outputs on the falling edge. A check after N pulse cycles therefore sees exactly N events applied. Divided cases count events against the ratio, and the leftover residue is carried into the next expected value.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    localparam int CNT_W   = 16;
    localparam int RES_W   = 3;
    localparam int LEN12_W = 12;
    localparam int LEN10_W = 10;
    localparam int LEN8_W  = 8;

    // control word bit positions
    localparam int B_FLAG = 0;
    localparam int B_IE   = 1;
    localparam int B_CLR  = 2;
    localparam int B_RSV  = 3;
    localparam int B_MODE = 4;
    localparam int B_DIV  = 6;
    localparam int B_SRC  = 8;
    localparam int B_LEN  = 11;

    localparam logic [CNT_W-1:0] CTL_KEEP =
        ~((CNT_W'(1) << B_CLR) | (CNT_W'(1) << B_RSV));

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_CONT = 2'd2,
        MODE_UPDN = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_MAIN = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef struct packed {
        logic [CNT_W-1:0] ctl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             dir_dn;
        logic             roll_pend;
    } tmb_state_t;

    function automatic logic [CNT_W-1:0] len_mask(input logic [1:0] len);
        logic [CNT_W-1:0] m;
        case (len)
            2'd1:    m = CNT_W'((1 << LEN12_W) - 1);
            2'd2:    m = CNT_W'((1 << LEN10_W) - 1);
            2'd3:    m = CNT_W'((1 << LEN8_W) - 1);
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmb_prescale.sv
module tmb_prescale
    import tmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic [1:0] div,
    input  logic       aux_evt,
    input  logic       main_evt,
    output logic       tick
);
    localparam int SUM_W = RES_W + 1;

    logic [RES_W-1:0] res_d, res_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] keep_mask;
    logic             evt;

    always_comb begin
        case (src_e'(src))
            SRC_AUX:  evt = aux_evt;
            SRC_MAIN: evt = main_evt;
            default:  evt = 1'b0;
        endcase
        sum       = {1'b0, res_q} + SUM_W'(evt);
        keep_mask = (SUM_W'(1) << div) - SUM_W'(1);
        tick      = (sum >> div) != '0;
        res_d     = RES_W'(sum & keep_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end
endmodule

// File: rtl/tmb_step.sv
module tmb_step
    import tmb_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [1:0]       len,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic             dir_dn,
    input  logic             roll_pend,
    output logic [CNT_W-1:0] cnt_n,
    output logic             dir_n,
    output logic             pend_n,
    output logic             ovf
);
    logic [CNT_W-1:0] msk, inc, dec;
    logic             dir_t;

    always_comb begin
        msk    = len_mask(len);
        inc    = (cnt + CNT_W'(1)) & msk;
        dec    = (cnt - CNT_W'(1)) & msk;
        cnt_n  = cnt;
        dir_n  = dir_dn;
        pend_n = roll_pend;
        ovf    = 1'b0;
        dir_t  = dir_dn;
        case (mode_e'(mode))
            MODE_UP: begin
                if (cnt == per || roll_pend) begin
                    cnt_n  = '0;
                    ovf    = 1'b1;
                    pend_n = 1'b0;
                end else begin
                    cnt_n = inc;
                end
            end
            MODE_CONT: begin
                cnt_n = inc;
                ovf   = (inc == '0);
            end
            MODE_UPDN: begin
                if (cnt >= per) dir_t = 1'b1;
                if (cnt == '0)  dir_t = 1'b0;
                dir_n = dir_t;
                if (dir_t) begin
                    cnt_n = dec;
                    ovf   = (dec == '0);
                end else begin
                    cnt_n = inc;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
    import tmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aux_evt,
    input  logic             main_evt,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] ctl_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic [CNT_W-1:0] per_rdata,
    output logic             cnt_down,
    output logic             ovf_flag,
    output logic             ovf_en
);
    tmb_state_t st_d, st_q;

    logic             tick;
    logic [1:0]       mode_q, len_q;
    logic [CNT_W-1:0] step_cnt;
    logic             step_dir, step_pend, step_ovf;

    assign mode_q = st_q.ctl[B_MODE +: 2];
    assign len_q  = st_q.ctl[B_LEN +: 2];

    tmb_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (st_q.ctl[B_SRC +: 2]),
        .div      (st_q.ctl[B_DIV +: 2]),
        .aux_evt  (aux_evt),
        .main_evt (main_evt),
        .tick     (tick)
    );

    tmb_step u_step (
        .mode      (mode_q),
        .len       (len_q),
        .cnt       (st_q.cnt),
        .per       (st_q.per),
        .dir_dn    (st_q.dir_dn),
        .roll_pend (st_q.roll_pend),
        .cnt_n     (step_cnt),
        .dir_n     (step_dir),
        .pend_n    (step_pend),
        .ovf       (step_ovf)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_wdata & CTL_KEEP;
            if (ctl_wdata[B_CLR]) st_d.cnt = '0;
        end
        if (cnt_we) begin
            st_d.cnt = cnt_wdata & len_mask(len_q);
        end
        if (tick && !ctl_we && !cnt_we) begin
            st_d.cnt       = step_cnt;
            st_d.dir_dn    = step_dir;
            st_d.roll_pend = step_pend;
            if (step_ovf) st_d.ctl[B_FLAG] = 1'b1;
        end
        if (per_we) begin
            st_d.per = per_wdata;
            if (mode_e'(mode_q) == MODE_UP && per_wdata < st_q.cnt)
                st_d.roll_pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl_rdata = st_q.ctl;
    assign cnt_rdata = st_q.cnt;
    assign per_rdata = st_q.per;
    assign cnt_down  = st_q.dir_dn;
    assign ovf_flag  = st_q.ctl[B_FLAG];
    assign ovf_en    = st_q.ctl[B_IE];
endmodule

// File: rtl/tmb_timebase_chk.sv
module tmb_timebase_chk
    import tmb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [CNT_W-1:0] ctl_wdata,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] ctl_rd,
    input logic [CNT_W-1:0] cnt
);
    // R4: a halted counter keeps its value
    a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd[B_MODE +: 2] == 2'd0 && !ctl_we && !cnt_we) |=> $stable(cnt));

    // R2: no event source, no movement
    a_r2_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_rd[B_SRC +: 2] == 2'd0 || ctl_rd[B_SRC +: 2] == 2'd3)
         && !ctl_we && !cnt_we) |=> $stable(cnt));

    // R8: counter writes are masked to the prior length
    a_r8_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !ctl_we) |=>
        cnt == ($past(cnt_wdata) & len_mask($past(ctl_rd[B_LEN +: 2]))));

    // R9: clear bit zeroes the counter
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[B_CLR] && !cnt_we) |=> cnt == '0);

    // R9: stored control word drops bits 2 and 3
    a_r9_ctl_store: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> ctl_rd == ($past(ctl_wdata) & CTL_KEEP));

    // R11: flag is sticky without a control write
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd[B_FLAG] && !ctl_we) |=> ctl_rd[B_FLAG]);

    // R6: a newly set overflow flag always coincides with a zero count
    a_r6_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_rd[B_FLAG]) && !$past(ctl_we)) |-> cnt == '0);
endmodule

bind tmb_timebase tmb_timebase_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .ctl_rd    (ctl_rdata),
    .cnt       (cnt_rdata)
);

// File: tb/tmb_timebase_bench.sv
module tmb_timebase_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aux_evt = 1'b0, main_evt = 1'b0;
    logic        ctl_we = 1'b0, cnt_we = 1'b0, per_we = 1'b0;
    logic [15:0] ctl_wdata = '0, cnt_wdata = '0, per_wdata = '0;
    logic [15:0] ctl_rdata, cnt_rdata, per_rdata;
    logic        cnt_down, ovf_flag, ovf_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tmb_timebase u_tmb_timebase (
        .clk(clk), .rst_n(rst_n), .aux_evt(aux_evt), .main_evt(main_evt),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .per_we(per_we), .per_wdata(per_wdata), .ctl_rdata(ctl_rdata),
        .cnt_rdata(cnt_rdata), .per_rdata(per_rdata), .cnt_down(cnt_down),
        .ovf_flag(ovf_flag), .ovf_en(ovf_en)
    );

    function automatic logic [15:0] cw(input int src, input int dv, input int mode,
                                       input int len, input bit clr, input bit ie);
        return 16'((len << 11) | (src << 8) | (dv << 6) | (mode << 4)
                   | (int'(clr) << 2) | (int'(ie) << 1));
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_per(input logic [15:0] v);
        @(negedge clk); per_we = 1'b1; per_wdata = v;
        @(negedge clk); per_we = 1'b0;
    endtask

    task automatic pulse(input bit use_aux, input int n);
        @(negedge clk);
        if (use_aux) aux_evt = 1'b1; else main_evt = 1'b1;
        repeat (n) @(negedge clk);
        aux_evt = 1'b0; main_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ctl", ctl_rdata, 16'h0);
        chk("R1 cnt", cnt_rdata, 16'h0);
        chk("R1 per", per_rdata, 16'h0);
        chk("R1 dir", {15'd0, cnt_down}, 16'h0);
    endtask

    task automatic t_stop();
        wr_ctl(cw(2, 0, 0, 0, 1, 0));
        wr_cnt(16'd7);
        pulse(0, 4);
        chk("R4 stop holds", cnt_rdata, 16'd7);
    endtask

    task automatic t_source();
        wr_ctl(cw(0, 0, 2, 0, 1, 0));
        pulse(0, 3); pulse(1, 3);
        chk("R2 src0 idle", cnt_rdata, 16'd0);
        wr_ctl(cw(3, 0, 2, 0, 1, 0));
        pulse(0, 3); pulse(1, 3);
        chk("R2 src3 idle", cnt_rdata, 16'd0);
        wr_ctl(cw(1, 0, 2, 0, 1, 0));
        pulse(0, 3);
        chk("R2 aux ignores main", cnt_rdata, 16'd0);
        pulse(1, 2);
        chk("R2 aux counts", cnt_rdata, 16'd2);
        wr_ctl(cw(2, 0, 2, 0, 1, 0));
        pulse(1, 2);
        chk("R2 main ignores aux", cnt_rdata, 16'd0);
    endtask

    task automatic t_divider();
        wr_ctl(cw(2, 2, 2, 0, 1, 0));
        pulse(0, 3);
        chk("R3 below ratio", cnt_rdata, 16'd0);
        pulse(0, 1);
        chk("R3 first tick", cnt_rdata, 16'd1);
        pulse(0, 5);
        chk("R3 residue kept", cnt_rdata, 16'd2);
        pulse(0, 3);
        chk("R3 residue completes", cnt_rdata, 16'd3);
    endtask

    task automatic t_cont();
        wr_ctl(cw(2, 0, 2, 3, 1, 0));
        wr_cnt(16'd250);
        pulse(0, 5);
        chk("R6 before wrap", cnt_rdata, 16'd255);
        chk("R6 no flag yet", {15'd0, ovf_flag}, 16'd0);
        pulse(0, 1);
        chk("R6 wrap cnt", cnt_rdata, 16'd0);
        chk("R6 wrap flag", {15'd0, ovf_flag}, 16'd1);
    endtask

    task automatic t_up();
        wr_ctl(cw(2, 0, 0, 0, 1, 0));
        wr_per(16'd4);
        wr_ctl(cw(2, 0, 1, 0, 0, 1));
        pulse(0, 4);
        chk("R5 at period", cnt_rdata, 16'd4);
        chk("R5 no flag", {15'd0, ovf_flag}, 16'd0);
        pulse(0, 1);
        chk("R5 roll cnt", cnt_rdata, 16'd0);
        chk("R5 roll flag", {15'd0, ovf_flag}, 16'd1);
        chk("R11 enable out", {15'd0, ovf_en}, 16'd1);
        pulse(0, 3);
        chk("R11 flag sticky", {15'd0, ovf_flag}, 16'd1);
        chk("R5 after roll", cnt_rdata, 16'd3);
        wr_ctl(cw(2, 0, 0, 0, 0, 0));
        chk("R11 flag cleared", {15'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_updn();
        wr_ctl(cw(2, 0, 0, 0, 1, 0));
        wr_per(16'd3);
        wr_ctl(cw(2, 0, 3, 0, 0, 0));
        pulse(0, 3);
        chk("R7 climb", cnt_rdata, 16'd3);
        chk("R7 dir up", {15'd0, cnt_down}, 16'd0);
        pulse(0, 1);
        chk("R7 turn", cnt_rdata, 16'd2);
        chk("R7 dir down", {15'd0, cnt_down}, 16'd1);
        pulse(0, 2);
        chk("R7 reach zero", cnt_rdata, 16'd0);
        chk("R7 flag", {15'd0, ovf_flag}, 16'd1);
        pulse(0, 1);
        chk("R7 rise again", cnt_rdata, 16'd1);
        chk("R7 dir up again", {15'd0, cnt_down}, 16'd0);
    endtask

    task automatic t_mask();
        wr_ctl(cw(2, 0, 2, 2, 1, 0));
        wr_cnt(16'hFFFF);
        chk("R8 write 10b", cnt_rdata, 16'h03FF);
        pulse(0, 1);
        chk("R8 inc 10b wrap", cnt_rdata, 16'h0000);
        chk("R8 wrap flag", {15'd0, ovf_flag}, 16'd1);
        wr_ctl(cw(2, 0, 0, 1, 1, 0));
        wr_cnt(16'hFFFF);
        chk("R8 write 12b", cnt_rdata, 16'h0FFF);
        wr_ctl(cw(2, 0, 0, 0, 1, 0));
        wr_cnt(16'hFFFF);
        chk("R8 write 16b", cnt_rdata, 16'hFFFF);
    endtask

    task automatic t_ctl();
        wr_ctl(cw(2, 0, 0, 0, 0, 0));
        wr_cnt(16'd100);
        wr_ctl(16'hFFFF);
        chk("R9 stored bits", ctl_rdata, 16'hFFF3);
        chk("R9 clear zeroes", cnt_rdata, 16'd0);
        chk("R11 flag bit out", {15'd0, ovf_flag}, 16'd1);
        wr_ctl(16'h000C);
        chk("R9 bits 2,3 dropped", ctl_rdata, 16'h0000);
    endtask

    task automatic t_pend();
        wr_ctl(cw(2, 0, 1, 0, 1, 0));
        wr_per(16'd50);
        wr_cnt(16'd10);
        wr_per(16'd20);
        pulse(0, 1);
        chk("R10 no roll when above", cnt_rdata, 16'd11);
        chk("R10 no flag", {15'd0, ovf_flag}, 16'd0);
        wr_per(16'd5);
        pulse(0, 1);
        chk("R10 forced roll", cnt_rdata, 16'd0);
        chk("R10 roll flag", {15'd0, ovf_flag}, 16'd1);
        pulse(0, 1);
        chk("R10 resumes", cnt_rdata, 16'd1);
    endtask

    task automatic t_prec();
        wr_ctl(cw(2, 0, 2, 0, 1, 0));
        @(negedge clk); cnt_we = 1'b1; cnt_wdata = 16'h0040; main_evt = 1'b1;
        @(negedge clk); cnt_we = 1'b0; main_evt = 1'b0;
        chk("R12 write wins", cnt_rdata, 16'h0040);
        pulse(0, 1);
        chk("R12 next tick", cnt_rdata, 16'h0041);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = cw(2, 0, 2, 0, 0, 0); main_evt = 1'b1;
        @(negedge clk); ctl_we = 1'b0; main_evt = 1'b0;
        chk("R12 ctl write drops tick", cnt_rdata, 16'h0041);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop();
        t_source();
        t_divider();
        t_cont();
        t_up();
        t_updn();
        t_mask();
        t_ctl();
        t_pend();
        t_prec();
        finish_run();
    end
endmodule